// File: doc/BRIEF.md
# Two-Wire Register Access Slave

This block lets an external two-wire bus master read and write an on-chip register file one byte at a time. Each register is 8, 16 or 32 bits wide. A small width lookup provided by the register file tells the block how many data bytes a register spans. The block listens on the clock and data lines through synchronisers. It takes part in the bus only by pulling the data line low through an open-drain enable.

A write frame carries three parts in order: the device address byte in write mode, a 16-bit register pointer sent high byte first, and then the register's data bytes. A read frame first loads the pointer with the same write-mode preamble. The master then issues a repeated START and the read-mode address byte, and the block streams the register out from its most significant byte down. The master acknowledges every byte except the final one, which it answers with a NACK before sending STOP. The block asserts a single write strobe once a register's full width has arrived.

Top module: `i2cr_slave`

## Requirements
- R1: After reset the block does not pull SDA low (`sda_oe` = 0) and `reg_we` is 0.
- R2: The block acknowledges an address byte only when its upper seven bits equal the device address 0x38 (0x70 selects write mode, 0x71 read mode, bit 0 being the direction). For any other address it leaves SDA released until the next START, and the frame writes nothing.
- R3: After a write-mode address byte, the next two bytes form the 16-bit register pointer, high byte first. The block acknowledges both, and `reg_addr` carries the pointer from then on.
- R4: The number of data bytes in a write is given by `reg_width`: code 0 means one byte, code 1 two bytes, codes 2 and 3 four bytes. Bytes arrive most significant first and are placed right-aligned in `reg_wdata`, with unused upper bits zero. `reg_we` pulses for exactly one clock after the final byte has been acknowledged. Any byte beyond the width gets a NACK.
- R5: A repeated START followed by 0x71 is acknowledged. The block then sends the addressed register's `reg_width`-determined bytes, most significant byte first and each byte MSB first.
- R6: When the master NACKs a read byte, or once the last byte of the register has been sent, the block keeps SDA released for the rest of the frame.
- R7: A START or STOP at any bit position ends the byte in progress without a write strobe. A STOP releases SDA, and a START restarts address-byte reception.
- R8: The block changes its SDA drive only while SCL is low, except when it releases SDA on a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_oe | output | 1 | 1 pulls the data line low |
| reg_addr | output | 16 | Register pointer presented to the register file |
| reg_wdata | output | 32 | Right-aligned write data |
| reg_we | output | 1 | One-clock write strobe |
| reg_rdata | input | 32 | Contents of the addressed register, right-aligned |
| reg_width | input | 2 | Width code of the addressed register (0: 8, 1: 16, 2/3: 32 bits) |

## Verification
Writes and reads are driven on registers of all three widths, including width code 2. This separates a byte count taken from the width lookup from a fixed count, and it shows whether a byte order reversal occurs at 16 or at 32 bits. A foreign device address tells ignoring a frame apart from merely withholding the acknowledge. A master NACK on the first of four read bytes tells stopping on NACK apart from stopping on byte count. A START in the middle of the address byte and a STOP in the middle of a data byte show that framing restarts and that a partial register never reaches the register file.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_DEV,
      PH_RAH,
      PH_RAL,
      PH_WR,
      PH_RD,
      PH_SKIP
   } phase_t;

   // bytes spanned by a register of the given width code
   function automatic logic [2:0] width_bytes(input logic [1:0] code);
      case (code)
         2'd0:    return 3'd1;
         2'd1:    return 3'd2;
         default: return 3'd4;
      endcase
   endfunction

endpackage

// File: rtl/i2cr_sync.sv
module i2cr_sync #(
   parameter int   W       = 2,
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("i2cr_sync: STAGES must be at least 2");
   end

   for (genvar b = 0; b < W; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= {STAGES{RST_VAL}};
         else        chain <= {chain[STAGES-2:0], d[b]};
      end
      assign q[b] = chain[STAGES-1];
   end

endmodule

// File: rtl/i2cr_line_events.sv
module i2cr_line_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_ev,
   output logic stop_ev
);

   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign scl_rise = scl_s & ~scl_q;
   assign scl_fall = ~scl_s & scl_q;
   assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2cr_engine.sv
module i2cr_engine
   import i2cr_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h38,
   parameter int         ADDR_W   = 16,
   parameter int         DATA_W   = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_ev,
   input  logic              stop_ev,
   input  logic              sda_s,
   input  logic [DATA_W-1:0] reg_rdata,
   input  logic [1:0]        reg_width,
   output logic              sda_oe,
   output logic [ADDR_W-1:0] reg_addr,
   output logic [DATA_W-1:0] reg_wdata,
   output logic              reg_we
);

   localparam int CNT_W = 4;

   phase_t              phase, nxt;
   logic [CNT_W-1:0]    cnt;
   logic                in_ack, mack, we_pend, we_q, oe;
   logic [7:0]          rx, tx;
   logic [2:0]          bidx;
   logic [ADDR_W-1:0]   ra;
   logic [DATA_W-1:0]   wbuf;

   logic [2:0] nb;
   logic [1:0] sh;
   logic [7:0] sel;
   logic       more;

   assign nb   = width_bytes(reg_width);
   assign sh   = 2'(nb - 3'd1 - bidx);
   assign sel  = reg_rdata[8*sh +: 8];
   assign more = (bidx < nb);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_IDLE;
         nxt     <= PH_IDLE;
         cnt     <= '0;
         in_ack  <= 1'b0;
         mack    <= 1'b0;
         we_pend <= 1'b0;
         we_q    <= 1'b0;
         oe      <= 1'b0;
         rx      <= '0;
         tx      <= '1;
         bidx    <= '0;
         ra      <= '0;
         wbuf    <= '0;
      end else begin
         we_q <= 1'b0;
         if (start_ev || stop_ev) begin
            phase   <= start_ev ? PH_DEV : PH_IDLE;
            cnt     <= '0;
            in_ack  <= 1'b0;
            oe      <= 1'b0;
            we_pend <= 1'b0;
         end else if (phase != PH_IDLE) begin
            if (scl_rise) begin
               if (in_ack) mack <= ~sda_s;
               else if (cnt != CNT_W'(8)) begin
                  rx  <= {rx[6:0], sda_s};
                  cnt <= cnt + CNT_W'(1);
               end
            end
            if (scl_fall) begin
               if (in_ack) begin
                  // end of the acknowledge slot
                  in_ack  <= 1'b0;
                  cnt     <= '0;
                  oe      <= 1'b0;
                  we_q    <= we_pend;
                  we_pend <= 1'b0;
                  phase   <= nxt;
                  if (nxt == PH_RD) begin
                     if ((phase == PH_DEV || mack) && more) begin
                        oe   <= ~sel[7];
                        tx   <= {sel[6:0], 1'b1};
                        bidx <= bidx + 3'd1;
                     end else begin
                        phase <= PH_SKIP;
                     end
                  end
               end else if (cnt == CNT_W'(8)) begin
                  // byte complete, enter the acknowledge slot
                  in_ack <= 1'b1;
                  oe     <= 1'b0;
                  nxt    <= PH_SKIP;
                  case (phase)
                     PH_DEV: if (rx[7:1] == DEV_ADDR) begin
                        oe   <= 1'b1;
                        nxt  <= rx[0] ? PH_RD : PH_RAH;
                        bidx <= '0;
                     end
                     PH_RAH: begin
                        ra[ADDR_W-1 -: 8] <= rx;
                        oe  <= 1'b1;
                        nxt <= PH_RAL;
                     end
                     PH_RAL: begin
                        ra[7:0] <= rx;
                        oe   <= 1'b1;
                        nxt  <= PH_WR;
                        bidx <= '0;
                        wbuf <= '0;
                     end
                     PH_WR: if (more) begin
                        wbuf    <= {wbuf[DATA_W-9:0], rx};
                        oe      <= 1'b1;
                        bidx    <= bidx + 3'd1;
                        we_pend <= (bidx == nb - 3'd1);
                        nxt     <= PH_WR;
                     end
                     PH_RD:   nxt <= PH_RD;
                     default: nxt <= PH_SKIP;
                  endcase
               end else if (phase == PH_RD && cnt != '0) begin
                  oe <= ~tx[7];
                  tx <= {tx[6:0], 1'b1};
               end
            end
         end
      end
   end

   assign sda_oe    = oe;
   assign reg_addr  = ra;
   assign reg_wdata = wbuf;
   assign reg_we    = we_q;

endmodule

// File: rtl/i2cr_slave.sv
module i2cr_slave #(
   parameter logic [6:0] DEV_ADDR    = 7'h38,
   parameter int         ADDR_W      = 16,
   parameter int         DATA_W      = 32,
   parameter int         SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   output logic [ADDR_W-1:0] reg_addr,
   output logic [DATA_W-1:0] reg_wdata,
   output logic              reg_we,
   input  logic [DATA_W-1:0] reg_rdata,
   input  logic [1:0]        reg_width
);

   if (ADDR_W != 16) begin : g_bad_addr
      $error("i2cr_slave: the register pointer is two bytes, ADDR_W must be 16");
   end
   if (DATA_W != 32) begin : g_bad_data
      $error("i2cr_slave: the widest register is four bytes, DATA_W must be 32");
   end

   logic scl_s, sda_s;
   logic scl_rise, scl_fall, start_ev, stop_ev;

   i2cr_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({scl_i, sda_i}),
      .q     ({scl_s, sda_s})
   );

   i2cr_line_events u_ev (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_s    (scl_s),
      .sda_s    (sda_s),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_ev (start_ev),
      .stop_ev  (stop_ev)
   );

   i2cr_engine #(.DEV_ADDR(DEV_ADDR), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_ev  (start_ev),
      .stop_ev   (stop_ev),
      .sda_s     (sda_s),
      .reg_rdata (reg_rdata),
      .reg_width (reg_width),
      .sda_oe    (sda_oe),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_we    (reg_we)
   );

endmodule

// File: rtl/i2cr_slave_chk.sv
module i2cr_slave_chk #(
   parameter int ADDR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              scl_i,
   input logic              sda_oe,
   input logic              reg_we,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              start_ev,
   input logic              stop_ev
);

   AST_WE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> !reg_we);                                            // R4

   AST_ADDR_HELD_AT_WE: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |-> $stable(reg_addr));                                  // R3

   AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      stop_ev |=> !sda_oe);                                           // R7

   AST_START_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      start_ev |=> !sda_oe);                                          // R7

   AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> (!scl_i || $past(start_ev) || $past(stop_ev))); // R8

endmodule

bind i2cr_slave i2cr_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .scl_i    (scl_i),
   .sda_oe   (sda_oe),
   .reg_we   (reg_we),
   .reg_addr (reg_addr),
   .start_ev (start_ev),
   .stop_ev  (stop_ev)
);

// File: tb/sim_i2cr_slave.sv
module sim_i2cr_slave;

   localparam int Q = 10;   // clocks per quarter bus-clock period

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        m_scl = 1'b1;
   logic        m_sda = 1'b1;
   logic        sda_bus;
   logic        sda_oe, reg_we;
   logic [15:0] reg_addr;
   logic [31:0] reg_wdata, reg_rdata;
   logic [1:0]  reg_width;

   logic [31:0] mem     [0:255];
   logic [31:0] exp_mem [0:255];
   logic [47:0] wq [$];
   logic [47:0] wcur;

   int  vectors = 0;
   int  fails   = 0;
   bit  quiet   = 1'b0;
   bit  done    = 1'b0;
   logic prev_oe = 1'b0;

   always #10 clk = ~clk;

   assign sda_bus   = m_sda & ~sda_oe;
   assign reg_rdata = mem[reg_addr[7:0]];
   assign reg_width = reg_addr[1:0];

   always @(posedge clk) if (reg_we) mem[reg_addr[7:0]] <= reg_wdata;

   i2cr_slave u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (m_scl),
      .sda_i     (sda_bus),
      .sda_oe    (sda_oe),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_we    (reg_we),
      .reg_rdata (reg_rdata),
      .reg_width (reg_width)
   );

   // per-clock comparison against the reference expectations
   always @(negedge clk) if (rst_n) begin
      vectors++;
      if (reg_we) begin
         if (wq.size() == 0) begin
            fails++;
            $display("FAIL R4: write strobe addr %h data %h, expected no write", reg_addr, reg_wdata);
         end else begin
            wcur = wq.pop_front();
            if ({reg_addr, reg_wdata} !== wcur) begin
               fails++;
               $display("FAIL R4: write %h/%h, expected %h/%h", reg_addr, reg_wdata, wcur[47:32], wcur[31:0]);
            end
         end
      end
      if (quiet && sda_oe) begin
         fails++;
         $display("FAIL R6: sda_oe=%b during a released frame, expected 0", sda_oe);
      end
      if (sda_oe !== prev_oe && m_scl) begin
         fails++;
         $display("FAIL R8: sda_oe changed to %b while SCL high, expected no change", sda_oe);
      end
      prev_oe = sda_oe;
   end

   function automatic int nbytes(input logic [1:0] c);
      return (c == 2'd0) ? 1 : (c == 2'd1) ? 2 : 4;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic wait_q;
      repeat (Q) @(negedge clk);
   endtask

   task automatic send_bit(input logic b);
      m_sda = b; wait_q;
      m_scl = 1'b1; wait_q; wait_q;
      m_scl = 1'b0; wait_q;
   endtask

   task automatic recv_bit(output logic b);
      m_sda = 1'b1; wait_q;
      m_scl = 1'b1; wait_q;
      b = sda_bus; wait_q;
      m_scl = 1'b0; wait_q;
   endtask

   task automatic do_start;
      m_sda = 1'b1; wait_q;
      m_scl = 1'b1; wait_q;
      m_sda = 1'b0; wait_q;
      m_scl = 1'b0; wait_q;
   endtask

   task automatic do_stop;
      m_sda = 1'b0; wait_q;
      m_scl = 1'b1; wait_q;
      m_sda = 1'b1; wait_q;
   endtask

   task automatic send_byte(input logic [7:0] d, output logic ack);
      logic a;
      for (int i = 7; i >= 0; i--) send_bit(d[i]);
      recv_bit(a);
      ack = ~a;
   endtask

   task automatic recv_byte(output logic [7:0] d, input logic nack);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         recv_bit(b);
         d[i] = b;
      end
      send_bit(nack);
   endtask

   task automatic pointer_phase(input logic [15:0] addr, input string req);
      logic a;
      do_start;
      send_byte(8'h70, a);        check({req, " R2 addr 0x70 ack"}, 32'(a), 32'd1);
      send_byte(addr[15:8], a);   check("R3 pointer high ack", 32'(a), 32'd1);
      send_byte(addr[7:0], a);    check("R3 pointer low ack", 32'(a), 32'd1);
   endtask

   task automatic write_reg(input logic [15:0] addr, input logic [31:0] data);
      logic a;
      int n;
      logic [31:0] m;
      n = nbytes(addr[1:0]);
      m = (n == 4) ? data : (data & ((32'd1 << (8 * n)) - 32'd1));
      wq.push_back({addr, m});
      exp_mem[addr[7:0]] = m;
      pointer_phase(addr, "write");
      for (int k = n - 1; k >= 0; k--) begin
         send_byte(m[8*k +: 8], a);
         check("R4 data byte ack", 32'(a), 32'd1);
      end
      do_stop;
      check("R7 released after STOP", 32'(sda_oe), 32'd0);
   endtask

   task automatic read_reg(input logic [15:0] addr);
      logic a;
      logic [7:0] b;
      logic [31:0] v;
      int n;
      n = nbytes(addr[1:0]);
      pointer_phase(addr, "read");
      do_start;
      send_byte(8'h71, a);        check("R5 addr 0x71 ack", 32'(a), 32'd1);
      v = '0;
      for (int k = 0; k < n; k++) begin
         recv_byte(b, (k == n - 1));
         v = {v[23:0], b};
      end
      do_stop;
      check("R5 read value", v, exp_mem[addr[7:0]]);
      check("R6 released after final NACK", 32'(sda_oe), 32'd0);
   endtask

   initial begin
      repeat (150000) @(negedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run still busy, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      logic a;
      logic [7:0] b;
      for (int i = 0; i < 256; i++) begin
         mem[i]     = 32'h5EED_0000 ^ (32'(i) * 32'h0101_0103);
         exp_mem[i] = mem[i];
      end
      repeat (5) @(negedge clk);
      check("R1 reset sda_oe", 32'(sda_oe), 32'd0);
      check("R1 reset reg_we", 32'(reg_we), 32'd0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      check("R1 idle sda_oe", 32'(sda_oe), 32'd0);

      // writes at all width codes
      write_reg(16'h0123, 32'hA1B2_C3D4);
      check("R3 pointer on reg_addr", 32'(reg_addr), 32'h0000_0123);
      write_reg(16'h0041, 32'h0000_BEEF);
      write_reg(16'h0010, 32'h0000_005A);
      write_reg(16'h0032, 32'h1357_9BDF);

      // byte beyond a 16-bit register is refused
      wq.push_back({16'h0041, 32'h0000_C0A7});
      exp_mem[8'h41] = 32'h0000_C0A7;
      pointer_phase(16'h0041, "overrun");
      send_byte(8'hC0, a); check("R4 16-bit byte 1 ack", 32'(a), 32'd1);
      send_byte(8'hA7, a); check("R4 16-bit byte 2 ack", 32'(a), 32'd1);
      send_byte(8'h99, a); check("R4 extra byte NACK", 32'(a), 32'd0);
      do_stop;

      // reads at all width codes
      read_reg(16'h0123);
      read_reg(16'h0041);
      read_reg(16'h0010);
      read_reg(16'h0032);
      read_reg(16'h0077);

      // foreign device address: whole frame ignored
      do_start;
      quiet = 1'b1;
      send_byte(8'h50, a); check("R2 foreign addr NACK", 32'(a), 32'd0);
      send_byte(8'h00, a);
      send_byte(8'h10, a);
      send_byte(8'hFF, a); check("R2 later byte NACK", 32'(a), 32'd0);
      quiet = 1'b0;
      do_stop;
      read_reg(16'h0010);

      // master NACK on first of four read bytes
      pointer_phase(16'h0123, "nack");
      do_start;
      send_byte(8'h71, a); check("R5 addr 0x71 ack", 32'(a), 32'd1);
      recv_byte(b, 1'b1);  check("R5 first byte", 32'(b), 32'(exp_mem[8'h23][31:24]));
      quiet = 1'b1;
      recv_byte(b, 1'b1);  check("R6 no drive after NACK", 32'(b), 32'h0000_00FF);
      quiet = 1'b0;
      do_stop;

      // START inside the address byte, then a normal write
      do_start;
      send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
      write_reg(16'h0013, 32'hCAFE_F00D);
      read_reg(16'h0013);

      // STOP inside a data write: no strobe, register unchanged
      pointer_phase(16'h0041, "abort");
      send_byte(8'h11, a); check("R4 first byte ack", 32'(a), 32'd1);
      send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
      do_stop;
      check("R7 STOP releases", 32'(sda_oe), 32'd0);
      read_reg(16'h0041);

      repeat (20) @(negedge clk);
      check("R4 all expected strobes seen", 32'(wq.size()), 32'd0);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule